// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs the external bus cycles of a 16-bit embedded processor whose 20-bit address shares pins with the data. A CPU-side requester and a DMA-side requester each present a word address, byte enables, a direction and write data. The controller takes one request at a time and steps it through the T-states T1, T2, T3, optional wait states TW, and T4. In T1 it puts the address out and pulses ALE. From T2 onward the shared pins carry data and the top four address pins carry cycle status. It also generates the read and write strobes, the bus status code and the transceiver controls DEN and DT/R, and it captures read data.

A cycle is stretched by wait states until ready is seen. Ready comes from a synchronous input sampled directly, or from an asynchronous input that first passes through a synchronizer. Another master can take the bus with a HOLD/HLDA handshake, and during that handover every bus output floats. While reset is applied the pins follow a fixed sequence. The pads sit outside the block, so each tri-stateable group is given as a value together with an output enable.

Top module: `busCycleCtl`

## Requirements
- R1: With ready present at the end of T3, a cycle occupies exactly four clocks (T1, T2, T3, T4). `cpuDone` or `dmaDone`, chosen by the cycle's owner, is high only during T4.
- R2: If neither ready path is asserted at the clock edge ending T3 or a TW, another TW follows. The read or write strobe stays low through every TW.
- R3: `aleOut` is high for T1 only. In T1, `adOut[15:1]` carries address bits 15..1, `adOut[0]` is the inverse of byte enable 0 (low selects the lower byte), `upperOut` carries address bits 19..16, `bheN` is the inverse of byte enable 1, and `adOe` is high.
- R4: From T2 through T4, `upperOut` bit 3 is 1 for a DMA cycle and 0 for a CPU cycle, and `upperOut` bits 2..0 are 0.
- R5: A read drives `rdN` low in T2, T3 and TW, holds `adOe` low from T2 to T4, and captures `adIn` at the edge where ready ends the cycle. The captured value appears on `rdData` in T4. A write drives `wrN` low in T2, T3 and TW, and drives `adOut` with the write data and `adOe` high from T2 to T4. `rdN` and `wrN` are never low together.
- R6: `dtR` is 1 for a write and 0 for a read from T1 through T4. `denN` is low in T2, T3 and TW, and for writes also in T4.
- R7: `statN` is 3'b101 for a read and 3'b110 for a write from T1 up to the last T3/TW. It is 3'b111 (passive) in T4 and in idle.
- R8: `ardy` goes through a two-flop synchronizer. If `ardy` is high during the clock that is two clocks before a ready-sampling edge, that edge ends the wait. `srdy` is used in the same clock it is driven.
- R9: HOLD is taken in idle or at the end of T4. One clock later `hlda` is high, `aleOut` is low, and `adOe`, `upperOe`, `bheOe`, `dtrOe` and `ctlOe` are all low until the clock after HOLD falls.
- R10: When HOLD, a DMA request and a CPU request meet in the same idle clock, they are served in the order HOLD, then DMA, then CPU.
- R11: While `rst` is high, `aleOut`, `hlda` and both done outputs are low. `adOe`, `upperOe`, `bheOe` and `dtrOe` are low. `rdN`, `wrN`, `denN` and `lockN` are high and `statN` is 3'b111. `ctlOe` is high for the first clock of reset and low afterwards.
- R12: At least one idle clock separates two cycles. In idle, `ctlOe` is high with passive values and the address/data, upper-address, byte-high and DT/R groups are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | CPU-side cycle request, held until done |
| cpuWrite | input | 1 | CPU cycle direction, 1 = write |
| cpuAddr | input | 19 | CPU word address, bits 19..1 |
| cpuWdata | input | 16 | CPU write data |
| cpuByteEn | input | 2 | CPU byte enables, bit 1 upper, bit 0 lower |
| cpuDone | output | 1 | CPU cycle in T4 |
| dmaReq | input | 1 | DMA-side cycle request, held until done |
| dmaWrite | input | 1 | DMA cycle direction, 1 = write |
| dmaAddr | input | 19 | DMA word address, bits 19..1 |
| dmaWdata | input | 16 | DMA write data |
| dmaByteEn | input | 2 | DMA byte enables |
| dmaDone | output | 1 | DMA cycle in T4 |
| rdData | output | 16 | Captured read data |
| adOut | output | 16 | Multiplexed address/data value |
| adOe | output | 1 | Drive enable for adOut |
| adIn | input | 16 | Multiplexed address/data pin input |
| upperOut | output | 4 | Address 19..16 in T1, status afterwards |
| upperOe | output | 1 | Drive enable for upperOut |
| bheN | output | 1 | Byte-high enable, active low |
| bheOe | output | 1 | Drive enable for bheN |
| aleOut | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = transmit |
| dtrOe | output | 1 | Drive enable for dtR |
| statN | output | 3 | Bus status code, active low |
| lockN | output | 1 | Bus lock, held inactive |
| ctlOe | output | 1 | Drive enable for rdN, wrN, denN, statN, lockN |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant to the other master |

## Verification
The interesting collision is HOLD arriving in the same clock as a pending request: in idle, where a DMA request is raised on the same edge as HOLD, and in the middle of a cycle, where HOLD rises during T2. In the first case the bench expects `hlda` one clock later and no ALE pulse until HOLD drops. After that it expects a normal DMA cycle. In the second case the bench expects the cycle to run to T4 and `hlda` to follow on the very next clock, with no idle clock in between. Simultaneous CPU and DMA requests are also raised, and the status bit in T2 through T4 shows which one was served first.

// File: rtl/busCyclePkg.sv
package busCyclePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } busState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCycle;   // latch the chosen request on this edge
    logic pickDma;     // source of the request being latched
    logic addrPhase;   // T1
    logic dataPhase;   // T2, T3, TW, T4
    logic captureRead; // sample adIn on this edge
    logic isWrite;     // direction of the cycle in flight
    logic isDma;       // owner of the cycle in flight
  } busStrobe_t;

  localparam logic [2:0] STAT_READ    = 3'b101;
  localparam logic [2:0] STAT_WRITE   = 3'b110;
  localparam logic [2:0] STAT_PASSIVE = 3'b111;

endpackage

// File: rtl/busCycleFsm.sv
module busCycleFsm
  import busCyclePkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  logic       dmaReq,
  input  logic       dmaWrite,
  input  logic       hold,
  input  logic       srdy,
  input  logic       ardySync,
  output busStrobe_t strobes,
  output logic       aleOut,
  output logic       rdN,
  output logic       wrN,
  output logic       denN,
  output logic       dtR,
  output logic [2:0] statN,
  output logic       lockN,
  output logic       ctlOe,
  output logic       busOe,
  output logic       hlda,
  output logic       cpuDone,
  output logic       dmaDone
);

  busState_e state, stateNext;
  logic cycWrite, cycDma;
  logic rstDly;
  logic ready, startCycle, strobeWin, inCycle;

  assign ready      = srdy | ardySync;
  assign startCycle = (state == ST_IDLE) && !hold && (dmaReq || cpuReq);
  assign strobeWin  = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign inCycle    = (state == ST_T1) || strobeWin || (state == ST_T4);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (hold)                  stateNext = ST_HOLD;
        else if (dmaReq || cpuReq) stateNext = ST_T1;
      end
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   stateNext = ready ? ST_T4 : ST_TW;
      ST_TW:   stateNext = ready ? ST_T4 : ST_TW;
      ST_T4:   stateNext = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: stateNext = hold ? ST_HOLD : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cycWrite <= 1'b0;
      cycDma   <= 1'b0;
    end else begin
      state <= stateNext;
      if (startCycle) begin
        cycDma   <= dmaReq;
        cycWrite <= dmaReq ? dmaWrite : cpuWrite;
      end
    end
  end

  // Remembers whether the previous clock was already in reset
  always_ff @(posedge clk) rstDly <= rst;

  always_comb begin
    strobes.loadCycle   = startCycle && !rst;
    strobes.pickDma     = dmaReq;
    strobes.addrPhase   = (state == ST_T1);
    strobes.dataPhase   = strobeWin || (state == ST_T4);
    strobes.captureRead = ((state == ST_T3) || (state == ST_TW)) && ready && !cycWrite;
    strobes.isWrite     = cycWrite;
    strobes.isDma       = cycDma;
  end

  always_comb begin
    if (rst) begin
      aleOut  = 1'b0;
      rdN     = 1'b1;
      wrN     = 1'b1;
      denN    = 1'b1;
      dtR     = 1'b0;
      statN   = STAT_PASSIVE;
      lockN   = 1'b1;
      ctlOe   = !rstDly;
      busOe   = 1'b0;
      hlda    = 1'b0;
      cpuDone = 1'b0;
      dmaDone = 1'b0;
    end else begin
      aleOut  = (state == ST_T1);
      rdN     = !(strobeWin && !cycWrite);
      wrN     = !(strobeWin && cycWrite);
      denN    = !(strobeWin || ((state == ST_T4) && cycWrite));
      dtR     = cycWrite;
      statN   = ((state == ST_T1) || strobeWin) ? (cycWrite ? STAT_WRITE : STAT_READ)
                                               : STAT_PASSIVE;
      lockN   = 1'b1;
      ctlOe   = (state != ST_HOLD);
      busOe   = inCycle;
      hlda    = (state == ST_HOLD);
      cpuDone = (state == ST_T4) && !cycDma;
      dmaDone = (state == ST_T4) && cycDma;
    end
  end

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    aleOut |=> !aleOut);                                           // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));                                              // R5
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpuDone, dmaDone}));                                 // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cpuDone || dmaDone) |=> !(cpuDone || dmaDone));               // R12

endmodule

// File: rtl/busCycleDatapath.sv
module busCycleDatapath
  import busCyclePkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  busStrobe_t                 strobes,
  input  logic                       busOe,
  input  logic [ADDR_W-1:1]          cpuAddr,
  input  logic [DATA_W-1:0]          cpuWdata,
  input  logic [1:0]                 cpuByteEn,
  input  logic [ADDR_W-1:1]          dmaAddr,
  input  logic [DATA_W-1:0]          dmaWdata,
  input  logic [1:0]                 dmaByteEn,
  input  logic [DATA_W-1:0]          adIn,
  input  logic                       ardy,
  output logic [DATA_W-1:0]          adOut,
  output logic                       adOe,
  output logic [ADDR_W-DATA_W-1:0]   upperOut,
  output logic                       upperOe,
  output logic                       bheN,
  output logic                       bheOe,
  output logic                       dtrOe,
  output logic [DATA_W-1:0]          rdData,
  output logic                       ardySync
);

  localparam int UPPER_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:1]      addrQ;
  logic [DATA_W-1:0]      wdataQ;
  logic [1:0]             beQ;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdData <= '0;
    end else begin
      if (strobes.loadCycle) begin
        addrQ  <= strobes.pickDma ? dmaAddr   : cpuAddr;
        wdataQ <= strobes.pickDma ? dmaWdata  : cpuWdata;
        beQ    <= strobes.pickDma ? dmaByteEn : cpuByteEn;
      end
      if (strobes.captureRead) rdData <= adIn;
    end
  end

  // Asynchronous ready synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= ardy;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], ardy};
      end
    end
  endgenerate
  assign ardySync = syncQ[SYNC_STAGES-1];

  always_comb begin
    adOut    = strobes.addrPhase ? {addrQ[DATA_W-1:1], ~beQ[0]} : wdataQ;
    adOe     = busOe && (strobes.addrPhase || (strobes.dataPhase && strobes.isWrite));
    upperOut = strobes.addrPhase ? addrQ[ADDR_W-1:DATA_W]
                                 : {strobes.isDma, {(UPPER_W-1){1'b0}}};
    upperOe  = busOe;
    bheN     = ~beQ[1];
    bheOe    = busOe;
    dtrOe    = busOe;
  end

  AST_CAPTURE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    strobes.captureRead |-> !adOe);                                // R5

endmodule

// File: rtl/busCycleCtl.sv
module busCycleCtl
  import busCyclePkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpuReq,
  input  logic                     cpuWrite,
  input  logic [ADDR_W-1:1]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuWdata,
  input  logic [1:0]               cpuByteEn,
  output logic                     cpuDone,
  input  logic                     dmaReq,
  input  logic                     dmaWrite,
  input  logic [ADDR_W-1:1]        dmaAddr,
  input  logic [DATA_W-1:0]        dmaWdata,
  input  logic [1:0]               dmaByteEn,
  output logic                     dmaDone,
  output logic [DATA_W-1:0]        rdData,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] upperOut,
  output logic                     upperOe,
  output logic                     bheN,
  output logic                     bheOe,
  output logic                     aleOut,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     denN,
  output logic                     dtR,
  output logic                     dtrOe,
  output logic [2:0]               statN,
  output logic                     lockN,
  output logic                     ctlOe,
  input  logic                     srdy,
  input  logic                     ardy,
  input  logic                     hold,
  output logic                     hlda
);

  busStrobe_t strobes;
  logic       busOe;
  logic       ardySync;

  busCycleFsm uFsm (
    .clk      (clk),
    .rst      (rst),
    .cpuReq   (cpuReq),
    .cpuWrite (cpuWrite),
    .dmaReq   (dmaReq),
    .dmaWrite (dmaWrite),
    .hold     (hold),
    .srdy     (srdy),
    .ardySync (ardySync),
    .strobes  (strobes),
    .aleOut   (aleOut),
    .rdN      (rdN),
    .wrN      (wrN),
    .denN     (denN),
    .dtR      (dtR),
    .statN    (statN),
    .lockN    (lockN),
    .ctlOe    (ctlOe),
    .busOe    (busOe),
    .hlda     (hlda),
    .cpuDone  (cpuDone),
    .dmaDone  (dmaDone)
  );

  busCycleDatapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDatapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .busOe     (busOe),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .cpuByteEn (cpuByteEn),
    .dmaAddr   (dmaAddr),
    .dmaWdata  (dmaWdata),
    .dmaByteEn (dmaByteEn),
    .adIn      (adIn),
    .ardy      (ardy),
    .adOut     (adOut),
    .adOe      (adOe),
    .upperOut  (upperOut),
    .upperOe   (upperOe),
    .bheN      (bheN),
    .bheOe     (bheOe),
    .dtrOe     (dtrOe),
    .rdData    (rdData),
    .ardySync  (ardySync)
  );

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!adOe && !upperOe && !bheOe && !dtrOe && !ctlOe && !aleOut)); // R9

endmodule

// File: tb/tb_busCycleCtl.sv
module tb_busCycleCtl;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpuReq, cpuWrite, dmaReq, dmaWrite;
  logic [19:1] cpuAddr, dmaAddr;
  logic [15:0] cpuWdata, dmaWdata;
  logic [1:0]  cpuByteEn, dmaByteEn;
  logic        cpuDone, dmaDone;
  logic [15:0] rdData, adOut, adIn;
  logic        adOe, upperOe, bheN, bheOe, aleOut, rdN, wrN, denN, dtR, dtrOe;
  logic [3:0]  upperOut;
  logic [2:0]  statN;
  logic        lockN, ctlOe, srdy, ardy, hold, hlda;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  busCycleCtl dut (
    .clk(clk), .rst(rst),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuByteEn(cpuByteEn), .cpuDone(cpuDone),
    .dmaReq(dmaReq), .dmaWrite(dmaWrite), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata),
    .dmaByteEn(dmaByteEn), .dmaDone(dmaDone),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .upperOut(upperOut), .upperOe(upperOe), .bheN(bheN), .bheOe(bheOe),
    .aleOut(aleOut), .rdN(rdN), .wrN(wrN), .denN(denN), .dtR(dtR), .dtrOe(dtrOe),
    .statN(statN), .lockN(lockN), .ctlOe(ctlOe),
    .srdy(srdy), .ardy(ardy), .hold(hold), .hlda(hlda)
  );

  function automatic logic [15:0] memFn(input logic [19:1] a);
    return a[16:1] ^ 16'hC35A ^ {a[19:17], 13'h0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issueReq(input bit dma, input bit wr, input logic [19:1] a,
                          input logic [15:0] wd, input logic [1:0] be);
    if (dma) begin
      dmaReq = 1'b1; dmaWrite = wr; dmaAddr = a; dmaWdata = wd; dmaByteEn = be;
    end else begin
      cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd; cpuByteEn = be;
    end
  endtask

  // Follows one cycle from T1 to T4; returns at the T4 sample point
  task automatic runCycle(input bit dma, input bit wr, input logic [19:1] a,
                          input logic [15:0] wd, input logic [1:0] be,
                          input int waits, input bit useAsync, input int holdAt);
    bit found = 0;
    string doneTag;
    for (int i = 0; i < 4 && !found; i++) begin
      @(negedge clk);
      if (aleOut === 1'b1) found = 1;
    end
    chk("R12", {31'h0, found}, 32'h1);
    if (!found) return;
    doneTag = useAsync ? "R8" : ((waits > 0) ? "R2" : "R1");
    for (int k = 0; k < 4 + waits; k++) begin
      bit isT1, isStr, isT4;
      if (k > 0) @(negedge clk);
      isT1  = (k == 0);
      isStr = (k >= 1) && (k <= 2 + waits);
      isT4  = (k == 3 + waits);
      srdy  = !useAsync && (k == 2 + waits);
      ardy  = useAsync && (k == waits);
      if (k == holdAt) hold = 1'b1;
      if (isT1) begin
        adIn = memFn(a);
        chk("R3", {aleOut, adOut, upperOut, bheN, adOe},
                  {1'b1, a[15:1], ~be[0], a[19:16], ~be[1], 1'b1});
      end else begin
        chk("R3", {31'h0, aleOut}, 32'h0);
        chk("R4", {28'h0, upperOut}, {28'h0, dma, 3'b000});
        chk("R5", {adOe, (wr ? adOut : 16'h0)}, {wr, (wr ? wd : 16'h0)});
      end
      chk("R5", {rdN, wrN}, {!(isStr && !wr), !(isStr && wr)});
      chk("R6", {denN, dtR, dtrOe}, {!(isStr || (isT4 && wr)), wr, 1'b1});
      chk("R7", {29'h0, statN}, {29'h0, (k <= 2 + waits) ? (wr ? 3'b110 : 3'b101) : 3'b111});
      chk(doneTag, {cpuDone, dmaDone}, {isT4 && !dma, isT4 && dma});
      if (isT4 && !wr) chk("R5", {16'h0, rdData}, {16'h0, memFn(a)});
      if (isT4) begin
        if (dma) dmaReq = 1'b0; else cpuReq = 1'b0;
      end
    end
    srdy = 1'b0;
    ardy = 1'b0;
  endtask

  task automatic checkIdle();
    @(negedge clk);
    chk("R12", {ctlOe, adOe, upperOe, bheOe, dtrOe, aleOut, rdN, wrN, denN, statN, hlda},
               {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 1'b0});
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cpuReq = 0; dmaReq = 0; cpuWrite = 0; dmaWrite = 0;
    cpuAddr = '0; dmaAddr = '0; cpuWdata = '0; dmaWdata = '0;
    cpuByteEn = 2'b11; dmaByteEn = 2'b11; adIn = '0; srdy = 0; ardy = 0; hold = 0;
    repeat (3) @(negedge clk);
    // R11: reset state after the first clock
    chk("R11", {ctlOe, adOe, upperOe, bheOe, dtrOe, aleOut, hlda, cpuDone, dmaDone},
               9'b0);
    chk("R11", {rdN, wrN, denN, lockN, statN}, {4'b1111, 3'b111});
    rst = 1'b0;
    checkIdle();

    // Directed cycles: both directions, both ready paths
    issueReq(0, 0, 19'h5_1234, 16'h0, 2'b11); runCycle(0, 0, 19'h5_1234, 16'h0, 2'b11, 0, 0, -1);
    checkIdle();
    issueReq(0, 1, 19'h7_FFFF, 16'hBEEF, 2'b01); runCycle(0, 1, 19'h7_FFFF, 16'hBEEF, 2'b01, 2, 0, -1);
    checkIdle();
    issueReq(1, 0, 19'h0_0F0F, 16'h0, 2'b10); runCycle(1, 0, 19'h0_0F0F, 16'h0, 2'b10, 0, 1, -1);
    checkIdle();
    issueReq(1, 1, 19'h2_AAAA, 16'h1357, 2'b11); runCycle(1, 1, 19'h2_AAAA, 16'h1357, 2'b11, 3, 1, -1);
    checkIdle();

    // R10: CPU and DMA in the same idle clock, DMA first
    issueReq(0, 0, 19'h1_1111, 16'h0, 2'b11);
    issueReq(1, 1, 19'h3_3333, 16'hA5A5, 2'b11);
    runCycle(1, 1, 19'h3_3333, 16'hA5A5, 2'b11, 1, 0, -1);
    runCycle(0, 0, 19'h1_1111, 16'h0, 2'b11, 0, 0, -1);
    checkIdle();

    // R9/R10: HOLD and a DMA request in the same idle clock
    hold = 1'b1;
    issueReq(1, 0, 19'h4_4444, 16'h0, 2'b11);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", {hlda, aleOut, adOe, upperOe, bheOe, dtrOe, ctlOe}, 7'b1000000);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R9", {30'h0, hlda, aleOut}, 32'h0);
    runCycle(1, 0, 19'h4_4444, 16'h0, 2'b11, 0, 0, -1);
    checkIdle();

    // R9: HOLD raised in T2 is taken right after T4
    issueReq(0, 0, 19'h6_0001, 16'h0, 2'b01);
    runCycle(0, 0, 19'h6_0001, 16'h0, 2'b01, 1, 0, 1);
    @(negedge clk);
    chk("R9", {hlda, aleOut, adOe, ctlOe}, 4'b1000);
    hold = 1'b0;
    checkIdle();

    // R11: reset applied in T2 of a read
    issueReq(0, 0, 19'h0_0042, 16'h0, 2'b11);
    @(negedge clk);
    @(negedge clk);
    chk("R5", {31'h0, rdN}, 32'h0);
    rst = 1'b1;
    cpuReq = 1'b0;
    #1;
    chk("R11", {ctlOe, rdN, wrN, denN, lockN, statN, adOe, upperOe, aleOut, hlda, cpuDone},
               {5'b11111, 3'b111, 5'b00000});
    @(negedge clk);
    chk("R11", {31'h0, ctlOe}, 32'h0);
    rst = 1'b0;
    checkIdle();

    // Random cycles
    for (int n = 0; n < 150; n++) begin
      bit dma = 1'($urandom_range(0, 1));
      bit wr  = 1'($urandom_range(0, 1));
      bit asy = 1'($urandom_range(0, 1));
      logic [19:1] a  = 19'($urandom);
      logic [15:0] wd = 16'($urandom);
      logic [1:0]  be = 2'($urandom_range(1, 3));
      int waits = int'($urandom_range(0, 3));
      issueReq(dma, wr, a, wd, be);
      runCycle(dma, wr, a, wd, be, waits, asy, -1);
      checkIdle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule